// File: doc/BRIEF.md
# Retriggerable LED Activity Stretcher

This block drives a single active-high status LED from the link, speed, transmit, receive and collision state of a network port. A 4-bit program code selects what the LED shows: the speed level, transmit activity, receive activity, the link level, or a combined view. In the combined views, link is the primary indication and activity or collision is the secondary one.

Single-cycle event strobes are too short to see. Each event channel therefore has a retriggerable stretch timer. The rising edge of an event loads the timer with a period chosen by a 2-bit duration code. The timer counts down on a 1 ms tick, and the LED stays lit while the count is nonzero. A new rising edge during the stretch reloads the full period. An enable input bypasses stretching so the LED shows the raw event level.

A tick-driven toggle divider provides the blink phase for the combined views. The asynchronous active-low reset is released through a two-flop synchronizer.

Top module: `led_activity_stretch`

## Requirements
- R1: During reset and after it is released, every stretch timer is clear and the blink phase is low, so the LED is off in the transmit view (code 1) while the transmit input is idle.
- R2: Program code 0 drives the LED from the speed input in the same cycle, with no stretching, whatever the state of the event inputs.
- R3: With stretching enabled, code 1 shows the stretched transmit event and code 2 shows the stretched receive event.
- R4: A rising edge on an event input loads that channel's timer, so the LED is on from the next cycle. The timers run whatever program code is selected.
- R5: Duration code 00 loads 30 ticks, 01 loads 60, 10 loads 100, and 11 also loads 100. After a single edge the LED stays on for exactly that many ticks.
- R6: A rising edge while the timer is running reloads the full period. An event held high does not reload. When an edge and a tick fall in the same cycle, the reload wins.
- R7: With stretching disabled (enable input 0), the LED in codes 1, 2, 4 and 5 follows the raw event level in the same cycle.
- R8: Code 3 drives the LED from the link input.
- R9: Code 4 (link with activity): while neither transmit nor receive activity is present, the LED equals the link input. While either is present (stretched, or raw when stretching is off), the LED equals the blink phase.
- R10: Code 5 (link with collision): the same as R9, with the collision channel as the secondary source.
- R11: The blink phase toggles after every 50 ticks, and it does not change in a cycle without a tick.
- R12: Codes 6 to 15 hold the LED off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle strobe per millisecond |
| tx_evt_i | input | 1 | Transmit event |
| rx_evt_i | input | 1 | Receive event |
| col_evt_i | input | 1 | Collision event |
| link_up_i | input | 1 | Link status level |
| speed_hi_i | input | 1 | Speed level, 1 = fast |
| prog_i | input | 4 | LED program code |
| stretch_en_i | input | 1 | Pulse stretch enable |
| dur_sel_i | input | 2 | Stretch duration code |
| led_o | output | 1 | LED drive, active high |

## Verification
Single-cycle strobes with no later events, measured with a tick on every cycle, show whether each duration code loads its own length, and that the reserved code loads 100. A second strobe in mid-stretch, compared with an event held high, shows a true edge reload apart from a level that merely persists. Long random runs follow, with sparse strobes, random tick spacing, and changing program, enable and duration codes. These runs cover the combined views while the blink phase advances, and check that timers keep running across program changes. The unused codes are also checked to stay dark while events arrive.

// File: rtl/led_stretch_pkg.sv
package led_stretch_pkg;

  // LED program codes; values 6..15 are unused and keep the LED dark
  typedef enum logic [3:0] {
    LP_SPEED    = 4'd0,
    LP_TX       = 4'd1,
    LP_RX       = 4'd2,
    LP_LINK     = 4'd3,
    LP_LINK_ACT = 4'd4,
    LP_LINK_COL = 4'd5
  } led_prog_e;

  // event channel indices
  localparam int unsigned N_EV   = 3;
  localparam int unsigned EV_TX  = 0;
  localparam int unsigned EV_RX  = 1;
  localparam int unsigned EV_COL = 2;

  // duration selector codes
  typedef enum logic [1:0] {
    DS_SHORT = 2'b00,
    DS_MID   = 2'b01,
    DS_LONG  = 2'b10,
    DS_RSVD  = 2'b11
  } dur_sel_e;

endpackage

// File: rtl/led_evt_timer.sv
module led_evt_timer
  import led_stretch_pkg::*;
#(
  parameter int unsigned DUR_SHORT = 30,
  parameter int unsigned DUR_MID   = 60,
  parameter int unsigned DUR_LONG  = 100,
  parameter int unsigned CNT_W     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ev_i,
  input  logic [1:0] dur_sel_i,
  output logic       active_o
);

  logic             ev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] reload;
  logic             rise;
  logic             cnt_nz;
  logic             cnt_en;

  // period selected at the moment of the edge
  always_comb begin
    case (dur_sel_e'(dur_sel_i))
      DS_SHORT: reload = CNT_W'(DUR_SHORT);
      DS_MID:   reload = CNT_W'(DUR_MID);
      default:  reload = CNT_W'(DUR_LONG);
    endcase
  end

  // next state: a fresh edge always reloads, otherwise count ticks down
  always_comb begin
    rise   = ev_i & ~ev_q;
    cnt_nz = |cnt_q;
    cnt_en = rise | (tick_i & cnt_nz);
    cnt_d  = rise ? reload : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ev_q <= ev_i;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign active_o = cnt_nz;

  AST_EDGE_LIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !ev_q) |=> active_o); // R4

  AST_ONLY_EDGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_i && !ev_q) |=> (cnt_q <= $past(cnt_q))); // R6

  AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !(ev_i && !ev_q) && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(ev_i && !ev_q)) |=> $stable(cnt_q)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) <= DUR_LONG)); // R5

endmodule

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int unsigned HALF = 50,
  parameter int unsigned BW   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic phase_o
);

  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_d;
  logic          phase_q;
  logic          phase_d;
  logic          wrap;

  always_comb begin
    wrap    = tick_i && (cnt_q == BW'(HALF - 1));
    cnt_d   = wrap ? '0 : (cnt_q + BW'(1));
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(phase_o)); // R11

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) < HALF)); // R11

endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import led_stretch_pkg::*;
(
  input  logic [3:0]      prog_i,
  input  logic            stretch_en_i,
  input  logic            speed_i,
  input  logic            link_i,
  input  logic [N_EV-1:0] raw_i,
  input  logic [N_EV-1:0] str_i,
  input  logic            phase_i,
  output logic            led_o
);

  logic [N_EV-1:0] ev_view;
  logic            act_any;

  always_comb begin
    ev_view = stretch_en_i ? str_i : raw_i;
    act_any = ev_view[EV_TX] | ev_view[EV_RX];
    case (led_prog_e'(prog_i))
      LP_SPEED:    led_o = speed_i;
      LP_TX:       led_o = ev_view[EV_TX];
      LP_RX:       led_o = ev_view[EV_RX];
      LP_LINK:     led_o = link_i;
      LP_LINK_ACT: led_o = act_any ? phase_i : link_i;
      LP_LINK_COL: led_o = ev_view[EV_COL] ? phase_i : link_i;
      default:     led_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/led_activity_stretch.sv
module led_activity_stretch
  import led_stretch_pkg::*;
#(
  parameter int unsigned DUR_SHORT  = 30,
  parameter int unsigned DUR_MID    = 60,
  parameter int unsigned DUR_LONG   = 100,
  parameter int unsigned BLINK_HALF = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms_i,
  input  logic       tx_evt_i,
  input  logic       rx_evt_i,
  input  logic       col_evt_i,
  input  logic       link_up_i,
  input  logic       speed_hi_i,
  input  logic [3:0] prog_i,
  input  logic       stretch_en_i,
  input  logic [1:0] dur_sel_i,
  output logic       led_o
);

  localparam int unsigned CNT_W = $clog2(DUR_LONG + 1);
  localparam int unsigned BW    = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [N_EV-1:0] raw_ev;
  logic [N_EV-1:0] str_ev;
  logic            blink_phase;

  assign raw_ev[EV_TX]  = tx_evt_i;
  assign raw_ev[EV_RX]  = rx_evt_i;
  assign raw_ev[EV_COL] = col_evt_i;

  for (genvar g = 0; g < N_EV; g++) begin : g_chan
    led_evt_timer #(
      .DUR_SHORT (DUR_SHORT),
      .DUR_MID   (DUR_MID),
      .DUR_LONG  (DUR_LONG),
      .CNT_W     (CNT_W)
    ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick_i    (tick_ms_i),
      .ev_i      (raw_ev[g]),
      .dur_sel_i (dur_sel_i),
      .active_o  (str_ev[g])
    );
  end

  led_blink_div #(
    .HALF (BLINK_HALF),
    .BW   (BW)
  ) u_blink (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick_ms_i),
    .phase_o (blink_phase)
  );

  led_src_mux u_mux (
    .prog_i       (prog_i),
    .stretch_en_i (stretch_en_i),
    .speed_i      (speed_hi_i),
    .link_i       (link_up_i),
    .raw_i        (raw_ev),
    .str_i        (str_ev),
    .phase_i      (blink_phase),
    .led_o        (led_o)
  );

  AST_UNUSED_DARK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_i > 4'd5) |-> !led_o); // R12

  AST_LINK_VIEW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_i == 4'd3) |-> (led_o == link_up_i)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> (str_ev == '0) && !blink_phase); // R1

endmodule

// File: tb/sim_led_activity_stretch.sv
`timescale 1ns/1ps
module sim_led_activity_stretch;

  localparam int unsigned D0 = 30;
  localparam int unsigned D1 = 60;
  localparam int unsigned D2 = 100;
  localparam int unsigned BH = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tx = 1'b0;
  logic       rx = 1'b0;
  logic       col = 1'b0;
  logic       link = 1'b0;
  logic       speed = 1'b0;
  logic [3:0] prog = 4'd1;
  logic       se = 1'b1;
  logic [1:0] dsel = 2'b00;
  logic       led;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  always #5 clk = ~clk;

  led_activity_stretch #(
    .DUR_SHORT (D0), .DUR_MID (D1), .DUR_LONG (D2), .BLINK_HALF (BH)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .tick_ms_i (tick),
    .tx_evt_i (tx), .rx_evt_i (rx), .col_evt_i (col),
    .link_up_i (link), .speed_hi_i (speed), .prog_i (prog),
    .stretch_en_i (se), .dur_sel_i (dsel), .led_o (led)
  );

  // reference state built from the requirements
  int unsigned m_cnt [3];
  logic        m_prev [3];
  int unsigned m_bc;
  logic        m_ph;

  function automatic int unsigned dur_of(input logic [1:0] c);
    case (c)
      2'b00:   return D0;
      2'b01:   return D1;
      default: return D2;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i]  <= 0;
        m_prev[i] <= 1'b0;
      end
      m_bc <= 0;
      m_ph <= 1'b0;
    end else begin
      logic [2:0] ev;
      ev = {col, rx, tx};
      for (int i = 0; i < 3; i++) begin
        if (ev[i] && !m_prev[i]) m_cnt[i] <= dur_of(dsel);
        else if (tick && m_cnt[i] != 0) m_cnt[i] <= m_cnt[i] - 1;
        m_prev[i] <= ev[i];
      end
      if (tick) begin
        if (m_bc == BH - 1) begin
          m_bc <= 0;
          m_ph <= ~m_ph;
        end else begin
          m_bc <= m_bc + 1;
        end
      end
    end
  end

  function automatic logic exp_led();
    logic [2:0] v;
    v[0] = se ? (m_cnt[0] != 0) : tx;
    v[1] = se ? (m_cnt[1] != 0) : rx;
    v[2] = se ? (m_cnt[2] != 0) : col;
    case (prog)
      4'd0:    return speed;
      4'd1:    return v[0];
      4'd2:    return v[1];
      4'd3:    return link;
      4'd4:    return (v[0] | v[1]) ? m_ph : link;
      4'd5:    return v[2] ? m_ph : link;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of();
    case (prog)
      4'd0:       return "R2";
      4'd1, 4'd2: return se ? "R3" : "R7";
      4'd3:       return "R8";
      4'd4:       return "R9";
      4'd5:       return "R10";
      default:    return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t prog=%0d actual=%b expected=%b", req, $time, prog, act, exp);
    end
  endtask

  // sample away from the active edge, then inputs may change
  task automatic step();
    @(negedge clk);
    check(tag_of(), led, exp_led());
  endtask

  task automatic count_int(input string req, input int unsigned act, input int unsigned exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    tx = 0; rx = 0; col = 0; tick = 1;
    repeat (n) step();
  endtask

  // single strobe with a tick every cycle; returns lit samples
  task automatic pulse_len(input logic [1:0] code, output int unsigned lit);
    prog = 4'd1; se = 1; dsel = code;
    quiet(D2 + 5);
    step(); tx = 1;
    lit = 0;
    repeat (D2 + 20) begin
      step(); tx = 0;
      if (led) lit++;
    end
  endtask

  initial begin
    int unsigned lit;
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", led, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", led, 1'b0);
    prog = 4'd0; speed = 1;
    step();
    check("R2", led, 1'b1);

    // R4: edge lights the LED on the next cycle
    prog = 4'd1; se = 1; dsel = 2'b00; tick = 0;
    step(); tx = 1;
    step(); check("R4", led, 1'b1); tx = 0;

    // R5: each duration code
    for (int c = 0; c < 4; c++) begin
      pulse_len(2'(c), lit);
      count_int("R5", lit, dur_of(2'(c)));
    end

    // R6: retrigger mid-stretch restarts the full period
    dsel = 2'b00; quiet(D2 + 5);
    step(); tx = 1;
    step(); tx = 0;
    repeat (19) step();
    tx = 1;
    lit = 0;
    repeat (D0 + 10) begin
      step(); tx = 0;
      if (led) lit++;
    end
    count_int("R6", lit, D0);

    // R6: a held level does not reload
    quiet(D2 + 5);
    step(); tx = 1;
    lit = 0;
    repeat (D0 + 10) begin
      step();
      if (led) lit++;
    end
    count_int("R6", lit, D0);
    check("R6", led, 1'b0);
    tx = 0;

    // R6: edge coinciding with a tick still loads the full period
    quiet(D2 + 5);
    tick = 1; step(); tx = 1;
    lit = 0;
    repeat (D0 + 10) begin
      step(); tx = 0;
      if (led) lit++;
    end
    count_int("R6", lit, D0);

    // R7: raw level follows in the same cycle
    se = 0; tick = 0;
    step(); tx = 1; #1; check("R7", led, 1'b1);
    step(); tx = 0; #1; check("R7", led, 1'b0);

    // R12: unused codes stay dark with activity
    prog = 4'd9; se = 1; link = 1; speed = 1;
    step(); tx = 1; rx = 1; col = 1;
    step(); check("R12", led, 1'b0);
    tx = 0; rx = 0; col = 0;

    // R11: blink phase seen through the link/collision view
    prog = 4'd5; se = 0; col = 1; tick = 1;
    repeat (3 * BH) step();
    col = 0;

    // random mix
    for (int k = 0; k < 12000; k++) begin
      step();
      if (k % 150 == 0) begin
        prog = 4'($urandom % 16);
        se   = ($urandom % 4) != 0;
        dsel = 2'($urandom % 4);
      end
      tick = ($urandom % 3) == 0;
      tx   = ($urandom % 25) == 0;
      rx   = ($urandom % 30) == 0;
      col  = ($urandom % 60) == 0;
      if ($urandom % 200 == 0) link = ~link;
      if ($urandom % 300 == 0) speed = ~speed;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule